// File: doc/BRIEF.md
# DMA Trigger Capture with Missed-Event Detection

This block sits at the front of a DMA channel controller and collects the triggers that start transfers on each of its channels. A channel can be started in three ways: by a hardware event line, by a software write, or by a chain trigger. A chain trigger is produced when a transfer completes and carries a completion code that names the next channel. The block keeps a separate pending flag for each of these three sources on every channel. It offers one pending channel at a time to the transfer-request path through a valid/ready handshake.

When a trigger arrives on a source that is already pending, the earlier trigger has not yet been served. The block records this in a sticky per-channel missed register. It does the same when the request path reports that a granted channel's parameter entry is null. An error interrupt pulse is raised only when the error state moves from clean to dirty. Software can clear errors, and it can ask the block to re-evaluate them so that an interrupt is raised again for errors that are still set. A small register port sets manual triggers, clears pending and missed bits, issues the evaluate strobe and reads back every status vector.

Top module: `dma_trig_capture`

## Requirements
- R1: Each channel keeps three independent pending flags (hardware event, manual, chain). A trigger on one source never sets, clears or flags a miss on another source, even on the same channel. Reads at address 0, 1 and 2 return the hardware, manual and chain pending vectors, and address 3 returns the missed vector, one bit per channel.
- R2: A trigger on a source whose flag for that channel is already set sets the channel's missed bit, unless that flag is being accepted or cleared in the same cycle. In that case the new trigger simply re-arms the flag and no miss is recorded.
- R3: When the request path accepts a grant with `req_null_i` high, the missed bit of the granted channel is set.
- R4: `err_irq_o` is a one-cycle pulse in the cycle after a missed bit becomes set, issued only if the missed register was all zero and `other_err_i` was low when the new miss arrived.
- R5: Source priority is hardware event (code 0) over manual (code 1) over chain (code 2), reported on `req_src_o`. Within the winning source, the lowest channel number is granted.
- R6: `req_valid_o` is high whenever any flag is pending. The granted flag clears on the edge where `req_valid_o` and `req_ready_i` are both high, and the next candidate is then offered.
- R7: A completion with `cmpl_valid_i` posts a chain trigger to channel `cmpl_code_i`. It does so only if `cmpl_chen_final_i` is set for a final completion (`cmpl_final_i`=1), or `cmpl_chen_inter_i` is set for an intermediate one.
- R8: Register writes act on a 64-bit mask. Address 0 sets manual flags. Addresses 1, 2 and 3 clear hardware, manual and chain flags. Address 4 clears missed bits. Missed bits stay set until cleared this way.
- R9: A write to address 5 (evaluate) produces an interrupt pulse in the next cycle if any missed bit is set or `other_err_i` is high.
- R10: A new miss that arrives while errors are already present, or while a clear leaves other errors set, produces no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_evt_i | input | 64 | Hardware event strobes, one per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (write and read) |
| reg_wdata_i | input | 64 | Register write mask |
| reg_rdata_o | output | 64 | Read data selected by `reg_addr_i` |
| cmpl_valid_i | input | 1 | Transfer completion report valid |
| cmpl_code_i | input | 6 | Completion code, the channel to chain to |
| cmpl_final_i | input | 1 | 1 = final completion, 0 = intermediate |
| cmpl_chen_final_i | input | 1 | Chaining enabled on final completion |
| cmpl_chen_inter_i | input | 1 | Chaining enabled on intermediate completion |
| req_valid_o | output | 1 | A channel is offered to the request path |
| req_ready_i | input | 1 | Request path accepts the offer |
| req_ch_o | output | 6 | Offered channel number |
| req_src_o | output | 2 | Offered trigger source (0 event, 1 manual, 2 chain) |
| req_null_i | input | 1 | Accepted channel's parameter entry is null |
| other_err_i | input | 1 | Some error bit in other error registers is set |
| err_irq_o | output | 1 | Error interrupt pulse |

## Verification
Two events can land on one channel in the same cycle: the acceptance of a pending flag and a fresh trigger on the same source. The bench provokes this by holding a hardware strobe on a channel for a second cycle while raising `req_ready_i` for its grant. It then judges through the register port that the flag is pending again and the missed vector is still zero. A second collision is a new miss that coincides with existing errors, either missed bits already set or `other_err_i` high. Here the bench expects the missed bit to be recorded with no interrupt, and the interrupt to appear only after an evaluate write.

// File: rtl/dtc_pkg.sv
// Shared types for the DMA trigger capture block.
// Assumes: three trigger sources, encoded in two bits; code order is also priority order.
package dtc_pkg;
    typedef enum logic [1:0] {
        SRC_EXT = 2'd0,
        SRC_MAN = 2'd1,
        SRC_CHN = 2'd2
    } trig_src_e;

    localparam logic [2:0] A_MAN_SET = 3'd0;
    localparam logic [2:0] A_EXT_CLR = 3'd1;
    localparam logic [2:0] A_MAN_CLR = 3'd2;
    localparam logic [2:0] A_CHN_CLR = 3'd3;
    localparam logic [2:0] A_MIS_CLR = 3'd4;
    localparam logic [2:0] A_EVAL    = 3'd5;
endpackage

// File: rtl/dtc_pend_bank.sv
// One bank of per-channel pending flags for a single trigger source.
// Does: latches triggers, clears on accept or software clear, reports
// triggers that hit a flag already set (missed events).
// Assumes: a trigger in the same cycle as a clear re-arms the flag, no miss.
module dtc_pend_bank #(
    parameter int unsigned NCH = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] trig_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] pend_o,
    output logic [NCH-1:0] miss_o
);
    logic [NCH-1:0] pend_q;

    // pending flag update: clear first, then new triggers win
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | trig_i;
    end

    // a miss is a trigger landing on a flag that survives this cycle
    always_comb miss_o = trig_i & pend_q & ~clr_i;

    assign pend_o = pend_q;

    assert_no_spurious_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(trig_i)) == '0));

    assert_clear_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((pend_q & $past(clr_i & ~trig_i)) == '0));
endmodule

// File: rtl/dtc_arbiter.sv
// Picks one pending channel per cycle for the request path.
// Does: source priority event > manual > chain, lowest channel within a source,
// and returns the one-hot accept mask per source.
// Assumes: inputs are registered pending vectors.
module dtc_arbiter
    import dtc_pkg::*;
#(
    parameter int unsigned NCH = 64,
    localparam int unsigned CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend_ext_i,
    input  logic [NCH-1:0] pend_man_i,
    input  logic [NCH-1:0] pend_chn_i,
    input  logic           ready_i,
    output logic           valid_o,
    output logic [CHW-1:0] ch_o,
    output trig_src_e      src_o,
    output logic [NCH-1:0] acc_ext_o,
    output logic [NCH-1:0] acc_man_o,
    output logic [NCH-1:0] acc_chn_o
);
    logic [NCH-1:0] sel_vec;
    logic [NCH-1:0] grant;

    // choose the winning source
    always_comb begin
        if (|pend_ext_i) begin
            sel_vec = pend_ext_i;
            src_o   = SRC_EXT;
        end else if (|pend_man_i) begin
            sel_vec = pend_man_i;
            src_o   = SRC_MAN;
        end else begin
            sel_vec = pend_chn_i;
            src_o   = SRC_CHN;
        end
    end

    // lowest set channel of the winning source
    always_comb begin
        ch_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (sel_vec[i]) ch_o = CHW'(i);
        end
    end

    // handshake and per-source accept masks
    always_comb begin
        valid_o   = |sel_vec;
        grant     = (valid_o && ready_i) ? (NCH'(1) << ch_o) : '0;
        acc_ext_o = (src_o == SRC_EXT) ? grant : '0;
        acc_man_o = (src_o == SRC_MAN) ? grant : '0;
        acc_chn_o = (src_o == SRC_CHN) ? grant : '0;
    end

    assert_event_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_ext_i) |-> (src_o == SRC_EXT && pend_ext_i[ch_o]));

    assert_lowest_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((sel_vec & ((NCH'(1) << ch_o) - NCH'(1))) == '0));

    assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_ext_o, acc_man_o, acc_chn_o}));
endmodule

// File: rtl/dtc_err.sv
// Missed-event register and error interrupt generator.
// Does: sticky per-channel missed bits with write-one-to-clear, and a
// one-cycle interrupt on a clean-to-dirty transition or an evaluate strobe.
// Assumes: a new miss in the same cycle as a clear of that bit keeps it set.
module dtc_err #(
    parameter int unsigned NCH = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] miss_i,
    input  logic [NCH-1:0] clr_i,
    input  logic           eval_i,
    input  logic           other_err_i,
    output logic [NCH-1:0] missed_o,
    output logic           irq_o
);
    logic [NCH-1:0] missed_q;
    logic           irq_q;
    logic           prior_err;

    // any error present before this cycle's updates
    always_comb prior_err = (|missed_q) || other_err_i;

    // sticky missed bits
    always_ff @(posedge clk) begin
        if (!rst_n) missed_q <= '0;
        else        missed_q <= (missed_q & ~clr_i) | miss_i;
    end

    // interrupt pulse on first error or on evaluate with errors present
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ((|miss_i) && !prior_err) || (eval_i && prior_err);
    end

    assign missed_o = missed_q;
    assign irq_o    = irq_q;

    assert_miss_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|miss_i) |=> ((missed_q & $past(miss_i)) == $past(miss_i)));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(missed_q) & ~missed_q & ~$past(clr_i)) == '0);

    assert_irq_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ((|missed_q) || $past(other_err_i)));

    assert_no_quiet_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prior_err && !eval_i) |=> !irq_q);
endmodule

// File: rtl/dma_trig_capture.sv
// Top of the DMA trigger capture block.
// Does: decodes register writes and completion reports into triggers and
// clears, holds three pending banks, arbitrates them to the request path,
// and tracks missed events and the error interrupt.
// Assumes: one register access per cycle; completion reports are single-cycle.
module dma_trig_capture
    import dtc_pkg::*;
#(
    parameter int unsigned NCH = 64,
    localparam int unsigned CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ext_evt_i,
    input  logic           reg_wr_i,
    input  logic [2:0]     reg_addr_i,
    input  logic [NCH-1:0] reg_wdata_i,
    output logic [NCH-1:0] reg_rdata_o,
    input  logic           cmpl_valid_i,
    input  logic [CHW-1:0] cmpl_code_i,
    input  logic           cmpl_final_i,
    input  logic           cmpl_chen_final_i,
    input  logic           cmpl_chen_inter_i,
    output logic           req_valid_o,
    input  logic           req_ready_i,
    output logic [CHW-1:0] req_ch_o,
    output logic [1:0]     req_src_o,
    input  logic           req_null_i,
    input  logic           other_err_i,
    output logic           err_irq_o
);
    logic [NCH-1:0] trig_man, trig_chn;
    logic [NCH-1:0] swclr_ext, swclr_man, swclr_chn, swclr_mis;
    logic [NCH-1:0] acc_ext, acc_man, acc_chn;
    logic [NCH-1:0] pend_ext, pend_man, pend_chn;
    logic [NCH-1:0] miss_ext, miss_man, miss_chn, miss_null, miss_all;
    logic [NCH-1:0] missed;
    logic           eval;
    logic           chain_fire;
    trig_src_e      arb_src;

    // register write decode into set and clear masks
    always_comb begin
        trig_man  = (reg_wr_i && reg_addr_i == A_MAN_SET) ? reg_wdata_i : '0;
        swclr_ext = (reg_wr_i && reg_addr_i == A_EXT_CLR) ? reg_wdata_i : '0;
        swclr_man = (reg_wr_i && reg_addr_i == A_MAN_CLR) ? reg_wdata_i : '0;
        swclr_chn = (reg_wr_i && reg_addr_i == A_CHN_CLR) ? reg_wdata_i : '0;
        swclr_mis = (reg_wr_i && reg_addr_i == A_MIS_CLR) ? reg_wdata_i : '0;
        eval      = reg_wr_i && (reg_addr_i == A_EVAL);
    end

    // completion report to chain trigger
    always_comb begin
        chain_fire = cmpl_valid_i &&
                     (cmpl_final_i ? cmpl_chen_final_i : cmpl_chen_inter_i);
        trig_chn   = chain_fire ? (NCH'(1) << cmpl_code_i) : '0;
    end

    // null entry seen on an accepted grant
    always_comb miss_null = (acc_ext | acc_man | acc_chn) & {NCH{req_null_i}};

    // all miss sources merged into one vector
    always_comb miss_all = miss_ext | miss_man | miss_chn | miss_null;

    // status read mux
    always_comb begin
        case (reg_addr_i)
            3'd0:    reg_rdata_o = pend_ext;
            3'd1:    reg_rdata_o = pend_man;
            3'd2:    reg_rdata_o = pend_chn;
            3'd3:    reg_rdata_o = missed;
            default: reg_rdata_o = '0;
        endcase
    end

    dtc_pend_bank #(.NCH(NCH)) u_bank_ext (
        .clk(clk), .rst_n(rst_n), .trig_i(ext_evt_i), .clr_i(acc_ext | swclr_ext),
        .pend_o(pend_ext), .miss_o(miss_ext));

    dtc_pend_bank #(.NCH(NCH)) u_bank_man (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_man), .clr_i(acc_man | swclr_man),
        .pend_o(pend_man), .miss_o(miss_man));

    dtc_pend_bank #(.NCH(NCH)) u_bank_chn (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_chn), .clr_i(acc_chn | swclr_chn),
        .pend_o(pend_chn), .miss_o(miss_chn));

    dtc_arbiter #(.NCH(NCH)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .pend_ext_i(pend_ext), .pend_man_i(pend_man), .pend_chn_i(pend_chn),
        .ready_i(req_ready_i), .valid_o(req_valid_o), .ch_o(req_ch_o),
        .src_o(arb_src), .acc_ext_o(acc_ext), .acc_man_o(acc_man), .acc_chn_o(acc_chn));

    dtc_err #(.NCH(NCH)) u_err (
        .clk(clk), .rst_n(rst_n), .miss_i(miss_all), .clr_i(swclr_mis),
        .eval_i(eval), .other_err_i(other_err_i), .missed_o(missed), .irq_o(err_irq_o));

    assign req_src_o = arb_src;

    assert_chain_posted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chain_fire |=> pend_chn[$past(cmpl_code_i)]);

    assert_null_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i && req_null_i) |=> missed[$past(req_ch_o)]);

    assert_valid_tracks_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o == ((|pend_ext) || (|pend_man) || (|pend_chn)));
endmodule

// File: tb/dma_trig_capture_tb.sv
// Self-checking bench: a priority vector table walked in a loop, then
// directed tests for reset, collisions, errors and chaining.
module dma_trig_capture_tb;
    localparam int unsigned NCH = 64;
    localparam int unsigned CHW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ext_evt_i = '0;
    logic           reg_wr_i = 1'b0;
    logic [2:0]     reg_addr_i = 3'd0;
    logic [NCH-1:0] reg_wdata_i = '0;
    logic [NCH-1:0] reg_rdata_o;
    logic           cmpl_valid_i = 1'b0;
    logic [CHW-1:0] cmpl_code_i = '0;
    logic           cmpl_final_i = 1'b0;
    logic           cmpl_chen_final_i = 1'b0;
    logic           cmpl_chen_inter_i = 1'b0;
    logic           req_valid_o;
    logic           req_ready_i = 1'b0;
    logic [CHW-1:0] req_ch_o;
    logic [1:0]     req_src_o;
    logic           req_null_i = 1'b0;
    logic           other_err_i = 1'b0;
    logic           err_irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dma_trig_capture #(.NCH(NCH)) u_dut (.*);

    // {ext_en, ext_ch, man_en, man_ch, chn_en, chn_ch, exp_ch, exp_src}
    localparam int NV = 6;
    localparam logic [28:0] TBL [NV] = '{
        {1'b1, 6'd5,  1'b1, 6'd2,  1'b1, 6'd1,  6'd5,  2'd0},
        {1'b0, 6'd0,  1'b1, 6'd40, 1'b1, 6'd3,  6'd40, 2'd1},
        {1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 6'd63, 6'd63, 2'd2},
        {1'b1, 6'd0,  1'b1, 6'd0,  1'b1, 6'd0,  6'd0,  2'd0},
        {1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 6'd17, 6'd17, 2'd2},
        {1'b1, 6'd33, 1'b1, 6'd10, 1'b1, 6'd62, 6'd33, 2'd0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic pulse_ext(input logic [63:0] v);
        @(negedge clk);
        ext_evt_i = v;
        @(negedge clk);
        ext_evt_i = '0;
    endtask

    task automatic drain();
        @(negedge clk);
        req_ready_i = 1'b1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (!req_valid_o) break;
        end
        req_ready_i = 1'b0;
    endtask

    task automatic completion(input logic [5:0] code, input logic fin,
                              input logic en_f, input logic en_i);
        @(negedge clk);
        cmpl_valid_i = 1'b1; cmpl_code_i = code; cmpl_final_i = fin;
        cmpl_chen_final_i = en_f; cmpl_chen_inter_i = en_i;
        @(negedge clk);
        cmpl_valid_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [28:0] e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R6, R4)
        chk("R6 reset valid", 64'(req_valid_o), 64'd0);
        chk("R4 reset irq", 64'(err_irq_o), 64'd0);
        rd(3'd3, d); chk("R8 reset missed", d, 64'd0);

        // priority table (R5)
        for (int i = 0; i < NV; i++) begin
            e = TBL[i];
            @(negedge clk);
            ext_evt_i    = e[28] ? (64'd1 << e[27:22]) : 64'd0;
            reg_wr_i     = e[21]; reg_addr_i = 3'd0;
            reg_wdata_i  = 64'd1 << e[20:15];
            cmpl_valid_i = e[14]; cmpl_code_i = e[13:8];
            cmpl_final_i = 1'b1; cmpl_chen_final_i = 1'b1; cmpl_chen_inter_i = 1'b0;
            @(negedge clk);
            ext_evt_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0; cmpl_valid_i = 1'b0;
            chk($sformatf("R5 vec%0d valid", i), 64'(req_valid_o), 64'd1);
            chk($sformatf("R5 vec%0d ch", i), 64'(req_ch_o), 64'(e[7:2]));
            chk($sformatf("R5 vec%0d src", i), 64'(req_src_o), 64'(e[1:0]));
            drain();
            chk($sformatf("R6 vec%0d drained", i), 64'(req_valid_o), 64'd0);
        end
        rd(3'd3, d); chk("R2 table no miss", d, 64'd0);

        // lowest channel within a source, then next after one accept (R5, R6)
        pulse_ext((64'd1 << 20) | (64'd1 << 11) | (64'd1 << 50));
        chk("R5 lowest ext", 64'(req_ch_o), 64'd11);
        req_ready_i = 1'b1;
        @(negedge clk);
        req_ready_i = 1'b0;
        chk("R6 next after accept", 64'(req_ch_o), 64'd20);
        rd(3'd0, d); chk("R6 accepted flag cleared", d, (64'd1 << 20) | (64'd1 << 50));
        drain();

        // source isolation (R1)
        pulse_ext(64'd1 << 3);
        rd(3'd0, d); chk("R1 ext pend", d, 64'd1 << 3);
        rd(3'd1, d); chk("R1 man untouched", d, 64'd0);
        rd(3'd2, d); chk("R1 chn untouched", d, 64'd0);
        wr(3'd0, 64'd1 << 3);
        rd(3'd1, d); chk("R1 man pend", d, 64'd1 << 3);
        rd(3'd3, d); chk("R1 no cross-source miss", d, 64'd0);
        chk("R1 no irq", 64'(err_irq_o), 64'd0);
        wr(3'd1, 64'd1 << 3);
        wr(3'd2, 64'd1 << 3);
        rd(3'd0, d); chk("R8 ext cleared", d, 64'd0);
        rd(3'd1, d); chk("R8 man cleared", d, 64'd0);

        // miss and first interrupt (R2, R4)
        @(negedge clk); ext_evt_i = 64'd1 << 7;
        @(negedge clk); ext_evt_i = 64'd1 << 7;
        @(negedge clk); ext_evt_i = '0;
        chk("R4 irq on first miss", 64'(err_irq_o), 64'd1);
        rd(3'd3, d); chk("R2 missed bit7", d, 64'd1 << 7);
        @(negedge clk);
        chk("R4 irq one cycle", 64'(err_irq_o), 64'd0);

        // further miss with errors present (R10)
        @(negedge clk); ext_evt_i = 64'd1 << 8;
        @(negedge clk); ext_evt_i = 64'd1 << 8;
        @(negedge clk); ext_evt_i = '0;
        chk("R10 no irq with errors", 64'(err_irq_o), 64'd0);
        rd(3'd3, d); chk("R10 both missed", d, (64'd1 << 7) | (64'd1 << 8));

        // evaluate re-arms (R9)
        wr(3'd5, 64'd0);
        chk("R9 eval irq", 64'(err_irq_o), 64'd1);
        @(negedge clk);
        chk("R9 eval pulse ends", 64'(err_irq_o), 64'd0);

        // partial clear (R8, R10)
        wr(3'd4, 64'd1 << 7);
        chk("R10 clear no irq", 64'(err_irq_o), 64'd0);
        rd(3'd3, d); chk("R8 partial clear", d, 64'd1 << 8);
        wr(3'd4, '1);
        rd(3'd3, d); chk("R8 all cleared", d, 64'd0);
        drain();

        // other error register dirty blocks interrupt (R4)
        other_err_i = 1'b1;
        @(negedge clk); ext_evt_i = 64'd1 << 9;
        @(negedge clk); ext_evt_i = 64'd1 << 9;
        @(negedge clk); ext_evt_i = '0;
        chk("R4 other error blocks irq", 64'(err_irq_o), 64'd0);
        other_err_i = 1'b0;
        wr(3'd4, '1);
        drain();

        // accept and new trigger in the same cycle (R2)
        @(negedge clk); ext_evt_i = 64'd1 << 9;
        @(negedge clk); ext_evt_i = 64'd1 << 9; req_ready_i = 1'b1;
        @(negedge clk); ext_evt_i = '0; req_ready_i = 1'b0;
        rd(3'd3, d); chk("R2 same-cycle no miss", d, 64'd0);
        rd(3'd0, d); chk("R2 same-cycle re-armed", d, 64'd1 << 9);
        chk("R2 same-cycle no irq", 64'(err_irq_o), 64'd0);
        drain();

        // null entry on accept (R3)
        pulse_ext(64'd1 << 4);
        @(negedge clk); req_ready_i = 1'b1; req_null_i = 1'b1;
        @(negedge clk); req_ready_i = 1'b0; req_null_i = 1'b0;
        rd(3'd3, d); chk("R3 null sets missed", d, 64'd1 << 4);
        chk("R3 null irq", 64'(err_irq_o), 64'd1);
        rd(3'd0, d); chk("R3 flag consumed", d, 64'd0);
        wr(3'd4, '1);

        // chaining enables (R7)
        completion(6'd12, 1'b1, 1'b1, 1'b0);
        completion(6'd13, 1'b0, 1'b1, 1'b0);
        completion(6'd14, 1'b0, 1'b0, 1'b1);
        completion(6'd15, 1'b1, 1'b0, 1'b1);
        rd(3'd2, d); chk("R7 chain enables", d, (64'd1 << 12) | (64'd1 << 14));
        wr(3'd3, '1);
        rd(3'd2, d); chk("R8 chain cleared", d, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule